// File: doc/BRIEF.md
# Clock page replacement selector

This block picks the physical frame to evict when a page fault needs a free frame. It holds one reference bit for each frame and a hand pointer into the circular order of frames. Every memory access reports its frame on the reference port, and the block sets that frame's bit. On a fault request the block looks at the frame under the hand, one frame per clock cycle. A frame whose bit is set gets its bit cleared and is passed over. The first frame found with a clear bit is returned as the victim, and the hand then rests one position past it.

The victim frame index is presented together with a one-cycle valid pulse. When the new page has been placed in that frame, the surrounding logic pulses the install strobe. This marks the frame as referenced. While a sweep is running the block raises busy, and any further fault request is dropped.

Top module: `clockVictimSelector`

## Requirements
- R1: After reset, busy and victimValid are 0, every reference bit is 0 and the hand points at frame 0. The first fault after reset therefore returns frame 0, with victimValid high in the cycle after the request.
- R2: A fault request seen while the block is idle starts a sweep at once. The frame under the hand is examined in that same cycle, and each further cycle examines the next frame in turn.
- R3: When the examined frame's bit is 0, the next cycle shows victimValid high for exactly that cycle, with victimFrame equal to that frame. The hand moves to the following frame, and the block returns to idle.
- R4: When the examined frame's bit is 1, the bit is cleared and the hand moves to the next frame. No victim is reported for that cycle.
- R5: The hand steps from frame FRAMES-1 to frame 0.
- R6: A cycle with refValid high sets the bit of frame refFrame.
- R7: If a reference and a sweep clear hit the same frame in the same cycle, the bit ends up 1.
- R8: An installStrobe pulse sets the bit of the most recently reported victim frame, the one held on victimFrame.
- R9: busy is high in every cycle after a sweep has examined a set bit and before its victim is reported. A fault request during those cycles is ignored and starts no second sweep.
- R10: If no reference or install occurs during a sweep, the sweep ends after at most FRAMES+1 examined frames, so victimValid rises at most FRAMES+1 cycles after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| refValid | input | 1 | A memory access touched frame refFrame this cycle |
| refFrame | input | IDX_W | Frame index of the access |
| faultReq | input | 1 | Request for a victim frame |
| installStrobe | input | 1 | The new page has been placed in the last victim frame |
| busy | output | 1 | Sweep in progress; fault requests are ignored |
| victimValid | output | 1 | One-cycle pulse: victimFrame holds a new victim |
| victimFrame | output | IDX_W | Index of the most recent victim frame |

## Verification
Before a fault, every one of the 256 reference-bit patterns of an 8-frame ring is loaded on top of whatever state earlier sweeps left behind. This covers hand positions all around the ring. It tells apart sweeps that stop at once, sweeps that skip a run of set bits, and sweeps that wrap past frame 7. The all-ones case shows the full pass of FRAMES+1 examinations. Further cases inject a reference into the frame being cleared, hold the fault line through a whole sweep, and install into a victim before a second full-ring sweep. These cases separate set-wins-over-clear, request dropping and install marking from plain sweep behaviour.

// File: rtl/clock_sel_pkg.sv
package clock_sel_pkg;

  // Strobes from the sweep control to the reference-bit datapath
  typedef struct packed {
    logic examine;      // look at the frame under the hand and advance it
    logic clearHead;    // clear the bit under the hand (it was set)
    logic latchVictim;  // the frame under the hand is the victim
  } sweepStrobe_t;

  typedef enum logic {
    SWEEP_IDLE = 1'b0,
    SWEEP_RUN  = 1'b1
  } sweepState_t;

endpackage

// File: rtl/clockRefDatapath.sv
module clockRefDatapath
  import clock_sel_pkg::*;
#(
  parameter int FRAMES = 8,
  parameter int IDX_W  = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  sweepStrobe_t     strobe,
  input  logic             refValid,
  input  logic [IDX_W-1:0] refFrame,
  input  logic             installStrobe,
  output logic             headRef,
  output logic             victimValid,
  output logic [IDX_W-1:0] victimFrame
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAMES - 1);

  logic [FRAMES-1:0] refBits;
  logic [IDX_W-1:0]  hand;
  logic [IDX_W-1:0]  nextHand;

  assign nextHand = (hand == LAST_IDX) ? '0 : hand + 1'b1;
  assign headRef  = refBits[hand];

  // One reference bit per frame; a set from a reference or install beats the clear
  for (genvar g = 0; g < FRAMES; g++) begin : g_frame
    logic setThis;
    logic clrThis;
    assign setThis = (refValid && refFrame == IDX_W'(g)) ||
                     (installStrobe && victimFrame == IDX_W'(g));
    assign clrThis = strobe.clearHead && (hand == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN)        refBits[g] <= 1'b0;
      else if (setThis) refBits[g] <= 1'b1;
      else if (clrThis) refBits[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               hand <= '0;
    else if (strobe.examine) hand <= nextHand;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimValid <= 1'b0;
      victimFrame <= '0;
    end else begin
      victimValid <= strobe.latchVictim;
      if (strobe.latchVictim) victimFrame <= hand;
    end
  end

  // R3
  hand_past_victim_chk: assert property (@(posedge clk) disable iff (!rstN)
    victimValid |-> hand == ((victimFrame == LAST_IDX) ? '0 : victimFrame + 1'b1));

  // R4
  clear_passed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearHead && !(refValid && refFrame == hand) &&
     !(installStrobe && victimFrame == hand)) |=> !refBits[$past(hand)]);

  // R7
  ref_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refFrame <= LAST_IDX) |=> refBits[$past(refFrame)]);

  // R8
  install_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    installStrobe |=> refBits[$past(victimFrame)]);

endmodule

// File: rtl/clockSweepCtrl.sv
module clockSweepCtrl
  import clock_sel_pkg::*;
#(
  parameter int FRAMES = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         faultReq,
  input  logic         headRef,
  input  logic         refValid,
  input  logic         installStrobe,
  output sweepStrobe_t strobe,
  output logic         busy
);

  localparam int LEN_W = $clog2(FRAMES + 2) + 1;

  sweepState_t state;
  sweepState_t stateNext;
  logic        examineNow;

  assign examineNow = (state == SWEEP_RUN) || faultReq;

  always_comb begin
    strobe.examine     = examineNow;
    strobe.clearHead   = examineNow && headRef;
    strobe.latchVictim = examineNow && !headRef;
    stateNext = (examineNow && headRef) ? SWEEP_RUN : SWEEP_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SWEEP_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == SWEEP_RUN);

  // Sweep length tracking used by the bound check
  logic [LEN_W-1:0] sweepLen;
  logic             disturbed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sweepLen  <= '0;
      disturbed <= 1'b0;
    end else if (examineNow) begin
      if (state == SWEEP_IDLE) begin
        sweepLen  <= LEN_W'(1);
        disturbed <= refValid || installStrobe;
      end else begin
        sweepLen  <= sweepLen + 1'b1;
        disturbed <= disturbed || refValid || installStrobe;
      end
    end
  end

  // R10
  sweep_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !disturbed) |-> sweepLen <= LEN_W'(FRAMES));

  // R2
  idle_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && faultReq) |-> (strobe.clearHead || strobe.latchVictim));

endmodule

// File: rtl/clockVictimSelector.sv
module clockVictimSelector
  import clock_sel_pkg::*;
#(
  parameter int FRAMES = 8,
  parameter int IDX_W  = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refValid,
  input  logic [IDX_W-1:0] refFrame,
  input  logic             faultReq,
  input  logic             installStrobe,
  output logic             busy,
  output logic             victimValid,
  output logic [IDX_W-1:0] victimFrame
);

  sweepStrobe_t strobe;
  logic         headRef;

  clockSweepCtrl #(.FRAMES(FRAMES)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .faultReq      (faultReq),
    .headRef       (headRef),
    .refValid      (refValid),
    .installStrobe (installStrobe),
    .strobe        (strobe),
    .busy          (busy)
  );

  clockRefDatapath #(.FRAMES(FRAMES), .IDX_W(IDX_W)) u_data (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .refValid      (refValid),
    .refFrame      (refFrame),
    .installStrobe (installStrobe),
    .headRef       (headRef),
    .victimValid   (victimValid),
    .victimFrame   (victimFrame)
  );

  // R9
  busy_no_victim_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !victimValid);

endmodule

// File: tb/clockVictimSelector_bench.sv
module clockVictimSelector_bench;
  localparam int FRAMES = 8;
  localparam int IDX_W = $clog2(FRAMES);
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refValid = 1'b0;
  logic [IDX_W-1:0] refFrame = '0;
  logic faultReq = 1'b0;
  logic installStrobe = 1'b0;
  logic busy;
  logic victimValid;
  logic [IDX_W-1:0] victimFrame;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Reference model of the requirements
  bit mBits [FRAMES];
  int mHand = 0;
  int mVictim = 0;
  bit mBusy = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clockVictimSelector #(.FRAMES(FRAMES)) u_clockVictimSelector (
    .clk(clk), .rstN(rstN), .refValid(refValid), .refFrame(refFrame),
    .faultReq(faultReq), .installStrobe(installStrobe), .busy(busy),
    .victimValid(victimValid), .victimFrame(victimFrame)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic applyRefs(input int mask);
    for (int i = 0; i < FRAMES; i++) begin
      if (mask[i]) begin
        @(negedge clk);
        refValid = 1'b1;
        refFrame = IDX_W'(i);
        @(posedge clk);
        mBits[i] = 1'b1;            // R6
      end
    end
    @(negedge clk);
    refValid = 1'b0;
  endtask

  task automatic install();
    @(negedge clk);
    installStrobe = 1'b1;
    @(posedge clk);
    mBits[mVictim] = 1'b1;          // R8
    @(negedge clk);
    installStrobe = 1'b0;
  endtask

  task automatic runFault(input bit inject, input int injStep, input bit hold);
    int step;
    bit done;
    bit examine;
    bit e;
    bit latched;
    int injFrame;
    step = 0;
    done = 0;
    while (!done && step < 3 * FRAMES) begin
      @(negedge clk);
      faultReq = (step == 0) || (hold && mBusy);
      injFrame = mHand;
      refValid = inject && (step == injStep);
      refFrame = IDX_W'(injFrame);
      @(posedge clk);
      examine = mBusy || faultReq;
      latched = 0;
      if (examine) begin
        e = mBits[mHand];
        if (e) mBits[mHand] = 1'b0;   // R4
        else begin
          mVictim = mHand;            // R3
          latched = 1;
        end
        mHand = (mHand + 1) % FRAMES; // R5
        mBusy = e;
      end
      if (refValid) mBits[injFrame] = 1'b1;  // R7: set wins
      #1;
      check(busy == mBusy, "R9 busy", int'(busy), int'(mBusy));
      if (latched) begin
        check(victimValid == 1'b1, "R3 victimValid", int'(victimValid), 1);
        check(victimFrame == IDX_W'(mVictim), "R3 victimFrame", int'(victimFrame), mVictim);
        if (!inject) check(step <= FRAMES, "R10 latency", step, FRAMES);
        done = 1;
      end else begin
        check(victimValid == 1'b0, "R4 no victim yet", int'(victimValid), 0);
      end
      step++;
    end
    check(done, "R10 sweep completes", int'(done), 1);
    @(negedge clk);
    faultReq = 1'b0;
    refValid = 1'b0;
    if (hold) begin
      for (int i = 0; i < FRAMES + 2; i++) begin
        @(posedge clk);
        #1;
        check(victimValid == 1'b0 && busy == 1'b0, "R9 held request ignored",
              int'(victimValid), 0);
      end
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    for (int i = 0; i < FRAMES; i++) mBits[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(victimValid == 1'b0, "R1 victimValid after reset", int'(victimValid), 0);
    // R1 / R2: first fault returns frame 0 immediately
    runFault(0, 0, 0);
    check(victimFrame == '0, "R1 first victim", int'(victimFrame), 0);

    // R2 R3 R4 R5 R6: every reference pattern over the ring
    for (int p = 0; p < 256; p++) begin
      applyRefs(p);
      runFault(0, 0, 0);
      if (p % 16 == 5) install();
    end

    // R7: reference collides with the clear of the first examined frame
    applyRefs(255);
    runFault(1, 0, 0);
    // R7: collision in the middle of a sweep
    applyRefs(255);
    runFault(1, 3, 0);

    // R9: request held through a full sweep
    applyRefs(255);
    runFault(0, 0, 1);

    // R8: install marks the victim so a full-ring sweep passes it
    applyRefs(0);
    runFault(0, 0, 0);
    install();
    applyRefs(255 & ~(1 << mVictim));
    runFault(0, 0, 0);
    check(victimFrame == IDX_W'(mVictim), "R8 installed frame skipped",
          int'(victimFrame), mVictim);

    summary();
  end
endmodule